// File: doc/BRIEF.md
# Three-Mode Local Register File

This block is a small on-chip memory of 64 words, each 20 bits wide: a 16-bit data field and a 4-bit control field stored side by side. It has one write port and one read port, and both may be used in the same clock cycle. A two-bit mode input selects how the ports address the array. The array can act as a plain addressed RAM, as a first-in first-out queue with its own pointers and occupancy status, or as a table that is read out in order. In the last mode, each read request advances an internal index between a configured start and end entry.

A separate initialization port writes words at explicit addresses. It is intended for loading the array before normal traffic starts, and it takes precedence over both normal ports. Reads are registered: the data appears one cycle after an accepted read, together with a one-cycle valid pulse. When the mode changes, the block resets its queue and sequence pointers in that same cycle. The stored words are left intact, so data loaded in one mode can be consumed in another.

Top module: `trimode_rf`

## Requirements
- R1: Each of the 64 entries stores a full 20-bit word. Bits [15:0] are the data field and bits [19:16] are the control field, and a read returns all 20 bits exactly as written.
- R2: A read request accepted in cycle N drives `rdData` and a one-cycle `rdValid` pulse after the clock edge that ends cycle N. `rdData` holds its value when no read is accepted.
- R3: In RAM mode, a read and a write to the same address in the same cycle return the word stored before that write.
- R4: In FIFO mode, words leave in the order they were written. `count` gives the occupancy (0 to 64), `full` is high when `count` is 64, and `empty` is high when `count` is 0.
- R5: In FIFO mode, a write with no read while full is ignored and leaves the contents unchanged. A read while empty is ignored: `rdValid` stays low and the pointers do not move.
- R6: In FIFO mode, a read together with a write while full is accepted. It returns the oldest word, stores the new one, and leaves `count` at 64.
- R7: In sequence mode, each read request returns the entry at the sequence index and then advances the index by one, wrapping from 63 to 0. After the entry equal to `seqEnd` has been read, the index returns to `seqStart`. Writes in this mode go to `wrAddr`.
- R8: A change of `mode` resets the FIFO pointers and count to zero and the sequence index to `seqStart`, effective for the operation in that same cycle. The array contents are kept.
- R9: While `initEn` is high, `initData` is written at `initAddr`, `wrEn` and `rdEn` are ignored, and no read is accepted.
- R10: Mode encoding: 0 selects RAM, 1 selects FIFO, 2 selects sequence, and 3 behaves as RAM.
- R11: After reset, `rdValid` is 0, `rdData` is 0, `count` is 0, `empty` is 1 and `full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode (0 RAM, 1 FIFO, 2 sequence, 3 RAM) |
| initEn | input | 1 | Initialization write enable |
| initAddr | input | 6 | Initialization write address |
| initData | input | 20 | Initialization write word |
| wrEn | input | 1 | Write request |
| wrAddr | input | 6 | Write address (RAM and sequence modes) |
| wrData | input | 20 | Write word |
| rdEn | input | 1 | Read request |
| rdAddr | input | 6 | Read address (RAM mode) |
| seqStart | input | 6 | First index of the read sequence |
| seqEnd | input | 6 | Last index of the read sequence |
| rdData | output | 20 | Registered read word |
| rdValid | output | 1 | Pulse marking a new read word |
| count | output | 7 | FIFO occupancy |
| full | output | 1 | FIFO holds 64 words |
| empty | output | 1 | FIFO holds no words |

## Verification
If a FIFO pointer is off, the next read returns a word out of order or a stale one. This shows on `rdData` one cycle after that read. If the occupancy count goes wrong, `full` or `empty` changes on the wrong edge, and a later write or read is dropped or accepted when it should not be. That shows up within at most 64 further operations, when the reference queue and the block disagree. A sequence index that wraps at the wrong entry returns the wrong word on the first read after `seqEnd`. A pointer that survives a mode switch corrupts the very first read in the new mode.

// File: rtl/trimode_rf_pkg.sv
package trimode_rf_pkg;
  localparam int unsigned DEPTH  = 64;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CTRL_W = 4;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned WORD_W = DATA_W + CTRL_W;
  localparam int unsigned CNT_W  = ADDR_W + 1;

  typedef enum logic [1:0] {
    MODE_RAM  = 2'd0,
    MODE_FIFO = 2'd1,
    MODE_SEQ  = 2'd2,
    MODE_RSV  = 2'd3
  } rfMode_e;

  typedef struct packed {
    logic              memWe;
    logic [ADDR_W-1:0] memWaddr;
    logic [WORD_W-1:0] memWdata;
    logic              memRe;
    logic [ADDR_W-1:0] memRaddr;
  } rfStrobe_t;
endpackage

// File: rtl/trimode_rf_ctrl.sv
module trimode_rf_ctrl
  import trimode_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              initEn,
  input  logic [ADDR_W-1:0] initAddr,
  input  logic [WORD_W-1:0] initData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] seqStart,
  input  logic [ADDR_W-1:0] seqEnd,
  output rfStrobe_t         strb,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [1:0]        modeQ;
  logic              modeChange;
  rfMode_e           modeEff;
  logic [ADDR_W-1:0] rdPtrQ, wrPtrQ, seqPtrQ;
  logic [CNT_W-1:0]  cntQ;
  logic [ADDR_W-1:0] rdPtr, wrPtr, seqPtr;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] rdPtrNext, wrPtrNext, seqPtrNext;
  logic [CNT_W-1:0]  cntNext;
  logic              doRd, doWr;

  assign modeChange = (mode != modeQ);

  always_comb begin
    case (mode)
      2'd1:    modeEff = MODE_FIFO;
      2'd2:    modeEff = MODE_SEQ;
      default: modeEff = MODE_RAM;
    endcase
  end

  // Fresh pointers apply in the same cycle as a mode change
  assign rdPtr  = modeChange ? '0 : rdPtrQ;
  assign wrPtr  = modeChange ? '0 : wrPtrQ;
  assign seqPtr = modeChange ? seqStart : seqPtrQ;
  assign cnt    = modeChange ? '0 : cntQ;

  always_comb begin
    strb       = '0;
    rdPtrNext  = rdPtr;
    wrPtrNext  = wrPtr;
    seqPtrNext = seqPtr;
    cntNext    = cnt;
    doRd       = 1'b0;
    doWr       = 1'b0;
    if (initEn) begin
      strb.memWe    = 1'b1;
      strb.memWaddr = initAddr;
      strb.memWdata = initData;
    end else begin
      case (modeEff)
        MODE_FIFO: begin
          doRd          = rdEn && (cnt != '0);
          doWr          = wrEn && ((cnt != FULL_CNT) || doRd);
          strb.memRe    = doRd;
          strb.memRaddr = rdPtr;
          strb.memWe    = doWr;
          strb.memWaddr = wrPtr;
          strb.memWdata = wrData;
          if (doRd) rdPtrNext = rdPtr + 1'b1;
          if (doWr) wrPtrNext = wrPtr + 1'b1;
          cntNext = cnt + CNT_W'(doWr) - CNT_W'(doRd);
        end
        MODE_SEQ: begin
          strb.memRe    = rdEn;
          strb.memRaddr = seqPtr;
          strb.memWe    = wrEn;
          strb.memWaddr = wrAddr;
          strb.memWdata = wrData;
          if (rdEn) seqPtrNext = (seqPtr == seqEnd) ? seqStart : seqPtr + 1'b1;
        end
        default: begin
          strb.memRe    = rdEn;
          strb.memRaddr = rdAddr;
          strb.memWe    = wrEn;
          strb.memWaddr = wrAddr;
          strb.memWdata = wrData;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_RAM;
      rdPtrQ  <= '0;
      wrPtrQ  <= '0;
      seqPtrQ <= '0;
      cntQ    <= '0;
    end else begin
      modeQ   <= mode;
      rdPtrQ  <= rdPtrNext;
      wrPtrQ  <= wrPtrNext;
      seqPtrQ <= seqPtrNext;
      cntQ    <= cntNext;
    end
  end

  assign count = cntQ;
  assign full  = (cntQ == FULL_CNT);
  assign empty = (cntQ == '0);

  logic fifoOp;
  assign fifoOp = (modeEff == MODE_FIFO) && !initEn && !modeChange;

  p_full_empty_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  p_ptr_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_FIFO) |-> (wrPtrQ == ADDR_W'(rdPtrQ + count[ADDR_W-1:0])));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOp && full && wrEn && !rdEn) |=> (full && $stable(wrPtrQ)));

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOp && empty && rdEn) |-> !strb.memRe);

  p_full_swap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOp && full && wrEn && rdEn) |=> full);

  p_seq_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((modeEff == MODE_SEQ) && !initEn && !modeChange && rdEn && (seqPtrQ == seqEnd))
      |=> (seqPtrQ == $past(seqStart)));
endmodule

// File: rtl/trimode_rf_data.sv
module trimode_rf_data
  import trimode_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         strb,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  logic [WORD_W-1:0] mem [DEPTH];

  // Read samples the array before this cycle's write lands
  always_ff @(posedge clk) begin
    if (strb.memWe) mem[strb.memWaddr] <= strb.memWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.memRe;
      if (strb.memRe) rdData <= mem[strb.memRaddr];
    end
  end

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !strb.memRe) |=> !rdValid);
endmodule

// File: rtl/trimode_rf.sv
module trimode_rf
  import trimode_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              initEn,
  input  logic [ADDR_W-1:0] initAddr,
  input  logic [WORD_W-1:0] initData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] seqStart,
  input  logic [ADDR_W-1:0] seqEnd,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  rfStrobe_t strb;

  trimode_rf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode),
    .initEn(initEn), .initAddr(initAddr), .initData(initData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .seqStart(seqStart), .seqEnd(seqEnd),
    .strb(strb), .count(count), .full(full), .empty(empty)
  );

  trimode_rf_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/trimode_rf_tb.sv
module trimode_rf_tb;
  import trimode_rf_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic initEn = 1'b0;
  logic [5:0] initAddr = '0;
  logic [19:0] initData = '0;
  logic wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [19:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [5:0] rdAddr = '0;
  logic [5:0] seqStart = '0;
  logic [5:0] seqEnd = '0;
  logic [19:0] rdData;
  logic rdValid;
  logic [6:0] count;
  logic full, empty;

  int checks = 0;
  int errors = 0;

  trimode_rf u_dut (
    .clk(clk), .rstN(rstN), .mode(mode),
    .initEn(initEn), .initAddr(initAddr), .initData(initData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .seqStart(seqStart), .seqEnd(seqEnd),
    .rdData(rdData), .rdValid(rdValid),
    .count(count), .full(full), .empty(empty)
  );

  always #4 clk = ~clk;

  // Reference state derived from the requirements
  logic [19:0] mMem [64];
  logic [5:0]  mRd = '0, mWr = '0, mSeq = '0;
  int          mCnt = 0;
  logic [1:0]  mModeQ = 2'd0;
  logic        eValid = 1'b0;
  logic [19:0] eData = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    bit mc = (mode != mModeQ);
    logic [5:0] rp = mc ? 6'd0 : mRd;
    logic [5:0] wp = mc ? 6'd0 : mWr;
    logic [5:0] sp = mc ? seqStart : mSeq;
    int c = mc ? 0 : mCnt;
    eValid = 1'b0;
    if (initEn) mMem[initAddr] = initData;
    else if (mode == 2'd1) begin
      bit dr = rdEn && (c > 0);
      bit dw = wrEn && ((c < 64) || dr);
      if (dr) begin eValid = 1'b1; eData = mMem[rp]; rp = rp + 6'd1; end
      if (dw) begin mMem[wp] = wrData; wp = wp + 6'd1; end
      c = c + int'(dw) - int'(dr);
    end else if (mode == 2'd2) begin
      if (rdEn) begin
        eValid = 1'b1; eData = mMem[sp];
        sp = (sp == seqEnd) ? seqStart : sp + 6'd1;
      end
      if (wrEn) mMem[wrAddr] = wrData;
    end else begin
      if (rdEn) begin eValid = 1'b1; eData = mMem[rdAddr]; end
      if (wrEn) mMem[wrAddr] = wrData;
    end
    mRd = rp; mWr = wp; mSeq = sp; mCnt = c; mModeQ = mode;
  endtask

  task automatic tick(input string tag);
    modelStep();
    @(posedge clk);
    #1;
    chk(rdValid == eValid, {tag, " rdValid"}, 32'(rdValid), 32'(eValid));
    chk(rdData == eData, {tag, " rdData"}, 32'(rdData), 32'(eData));
    chk(int'(count) == mCnt, {tag, " count"}, 32'(count), 32'(mCnt));
    chk(full == (mCnt == 64), {tag, " full"}, 32'(full), 32'(mCnt == 64));
    chk(empty == (mCnt == 0), {tag, " empty"}, 32'(empty), 32'(mCnt == 0));
    @(negedge clk);
  endtask

  task automatic idle();
    initEn = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] oldWord;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(rdValid == 1'b0, "R11 rdValid", 32'(rdValid), 0);
    chk(rdData == '0, "R11 rdData", 32'(rdData), 0);
    chk(count == '0, "R11 count", 32'(count), 0);
    chk(empty == 1'b1, "R11 empty", 32'(empty), 1);
    chk(full == 1'b0, "R11 full", 32'(full), 0);

    // R9 preload every entry while normal ports are driven and must be ignored
    for (int i = 0; i < 64; i++) begin
      initEn = 1'b1; initAddr = 6'(i); initData = 20'($urandom);
      wrEn = 1'b1; wrAddr = 6'($urandom); wrData = 20'($urandom);
      rdEn = 1'b1; rdAddr = 6'($urandom);
      tick("R9");
    end
    idle();
    // R1 read back all entries with control field
    for (int i = 0; i < 64; i++) begin
      rdEn = 1'b1; rdAddr = 6'(i);
      tick("R1");
    end
    idle(); tick("R2");
    wrEn = 1'b1; wrAddr = 6'd5; wrData = 20'hA5C3F; tick("R1");
    wrEn = 1'b0; rdEn = 1'b1; rdAddr = 6'd5; tick("R1");
    chk(rdData[19:16] == 4'hA && rdData[15:0] == 16'h5C3F, "R1 fields", 32'(rdData), 32'hA5C3F);

    // R3 read-during-write same address returns old word
    oldWord = rdData;
    wrEn = 1'b1; wrAddr = 6'd5; wrData = 20'h12345; rdEn = 1'b1; rdAddr = 6'd5; tick("R3");
    chk(rdData == oldWord, "R3 old data", 32'(rdData), 32'(oldWord));
    idle(); rdEn = 1'b1; tick("R3");
    chk(rdData == 20'h12345, "R3 new data", 32'(rdData), 32'h12345);

    // R2 random RAM traffic
    for (int i = 0; i < 300; i++) begin
      wrEn = 1'($urandom); wrAddr = 6'($urandom); wrData = 20'($urandom);
      rdEn = 1'($urandom); rdAddr = 6'($urandom);
      tick("R2");
    end
    // R10 mode 3 acts as RAM
    mode = 2'd3;
    for (int i = 0; i < 40; i++) begin
      wrEn = 1'($urandom); wrAddr = 6'($urandom % 8); wrData = 20'($urandom);
      rdEn = 1'($urandom); rdAddr = 6'($urandom % 8);
      tick("R10");
    end
    idle(); mode = 2'd0; tick("R10");

    // FIFO: R8 fresh pointers, R5 read on empty
    mode = 2'd1; rdEn = 1'b1; tick("R8");
    chk(rdValid == 1'b0, "R5 empty read", 32'(rdValid), 0);
    idle();
    for (int i = 0; i < 64; i++) begin
      wrEn = 1'b1; wrData = 20'($urandom); tick("R4");
    end
    chk(full == 1'b1, "R4 full at 64", 32'(full), 1);
    wrData = 20'hFFFFF; tick("R5");
    chk(count == 7'd64, "R5 write on full", 32'(count), 64);
    rdEn = 1'b1; wrData = 20'h0BEEF; tick("R6");
    chk(count == 7'd64 && rdValid, "R6 swap on full", 32'(count), 64);
    wrEn = 1'b0;
    for (int i = 0; i < 64; i++) tick("R4");
    chk(empty == 1'b1, "R4 empty after drain", 32'(empty), 1);
    tick("R5");
    chk(rdValid == 1'b0, "R5 empty read", 32'(rdValid), 0);
    for (int i = 0; i < 800; i++) begin
      wrEn = ($urandom % 100) < 55; wrData = 20'($urandom);
      rdEn = ($urandom % 100) < ((i / 200) % 2 == 0 ? 35 : 70);
      tick("R4");
    end

    // R7 sequence with wrap across 63 and a short window
    idle(); mode = 2'd2; seqStart = 6'd60; seqEnd = 6'd3;
    for (int i = 0; i < 24; i++) begin rdEn = 1'($urandom % 4 != 0); tick("R7"); end
    idle(); mode = 2'd0; tick("R8");
    mode = 2'd2; seqStart = 6'd10; seqEnd = 6'd14;
    for (int i = 0; i < 30; i++) begin
      rdEn = 1'b1; wrEn = 1'($urandom); wrAddr = 6'(10 + $urandom % 5); wrData = 20'($urandom);
      tick("R7");
    end
    // R8 switch to RAM keeps contents
    idle(); mode = 2'd0;
    for (int i = 0; i < 64; i++) begin rdEn = 1'b1; rdAddr = 6'(i); tick("R8"); end
    idle(); tick("R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule